// File: doc/BRIEF.md
# SDRAM Refresh and Timing Scheduler

This block sits on the controller side of a DDR SDRAM. It gates a stream of command requests from a simple front end: activate, read, write, precharge and mode-register load. A request is granted only when every minimum-spacing window that applies to it has run out. Each constraint is a countdown timer loaded when the governing command issues. All spacings are given in picoseconds and converted to whole clocks at elaboration.

A free-running interval counter produces a refresh obligation every average refresh period. While any obligation is owed, front-end requests are held off. If rows are open, the block first closes every bank with a precharge-all, once their active-time minimums allow it. After the precharge period it issues an auto-refresh and then blocks everything for the refresh cycle time. Owed refreshes accumulate up to a parameterised limit, so a long run of traffic can postpone them.

Top module: `sdram_cmd_pacer`

## Requirements
- R1: During and after reset, cmd_valid is low, no refresh is owed, and all spacing timers are expired, except the read block of R6.
- R2: A read or write to a bank is granted no earlier than RCD clocks after the activate to that bank, where a spacing of N clocks means the two grant edges are at least N edges apart.
- R3: An activate is granted only after three spacings have passed: RP clocks since that bank's last precharge, RC clocks since that bank's last activate, and RRD clocks since any activate.
- R4: A precharge to a bank is granted no earlier than RAS clocks after its activate.
- R5: After a mode-register load, nothing issues for MRD clocks, and a mode-register load waits until every bank's precharge period has passed.
- R6: A read is held for DLL_CYC clocks after reset and after each dll_relock pulse.
- R7: Every REFI clocks one refresh becomes owed (capped at MAX_OWED). While any is owed, req_ready stays low.
- R8: With a refresh owed and a row open, a precharge-all is issued once every open bank meets its RAS minimum. The auto-refresh is issued only when no bank is open and every bank's RP has passed.
- R9: After an auto-refresh, no command is granted or issued for RFC clocks.
- R10: A request is taken on a clock edge with req_valid and req_ready both high. The command appears on cmd_valid/cmd_code/cmd_bank in the following cycle. The encodings are 1 activate, 2 read, 3 write, 4 precharge, 5 mode load, 6 precharge-all, 7 auto-refresh. Request codes 0, 6 and 7 are never granted. A held request is not dropped.
- R11: Each spacing is ceil(t_ps / TCK_PS) clocks. At the default 10 ns clock the values are RCD 2, RP 2, RRD 2, RAS 5, RC 7, RFC 8, MRD 2, DLL_CYC 200 and REFI 1560.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dll_relock | input | 1 | Pulse: restarts the read hold window |
| req_valid | input | 1 | Front-end request present |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BANK_W | Requested bank |
| req_ready | output | 1 | Request may be taken this edge |
| cmd_valid | output | 1 | Command issued last edge |
| cmd_code | output | 3 | Issued command code |
| cmd_bank | output | BANK_W | Issued bank (0 for precharge-all and refresh) |

## Verification
The bench targets several corner cases. One is a refresh coming due while rows are open and their active-time minimum has not run out: a design that closes rows early would show the precharge-all a cycle or more ahead of the model. Another is a refresh on an edge where a precharge period is still running: a refresh issued too soon shows up against the model. The bench also covers front-end requests landing in the cycles right after a refresh or mode load, where a leaky block would raise req_ready. It covers reads right after a relock pulse and back-to-back activates across banks, which catch an off-by-one in the countdown load value. Held requests and illegal codes check that nothing is dropped or falsely granted.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

   typedef enum logic [2:0] {
      CMD_NONE = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_MODE = 3'd5,
      CMD_PALL = 3'd6,
      CMD_REF  = 3'd7
   } pacer_cmd_e;

   // whole clocks covering a spacing given in picoseconds
   function automatic int ps_to_cyc(input int t_ps, input int tck_ps);
      return (t_ps + tck_ps - 1) / tck_ps;
   endfunction

endpackage

// File: rtl/pacer_timer.sv
module pacer_timer #(
   parameter int CYC      = 2,
   parameter bit RST_FULL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic idle
);

   generate
      if (CYC <= 1) begin : g_pass
         assign idle = 1'b1;
      end else begin : g_count
         localparam int W = $clog2(CYC);
         localparam logic [W-1:0] LOADV = W'(CYC - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst)              cnt <= RST_FULL ? LOADV : '0;
            else if (start)       cnt <= LOADV;
            else if (cnt != '0)   cnt <= cnt - 1'b1;
         end

         assign idle = (cnt == '0);

         // R11
         timer_range_chk: assert property (@(posedge clk) disable iff (rst)
            cnt <= LOADV);
      end
   endgenerate

endmodule

// File: rtl/pacer_bank.sv
module pacer_bank #(
   parameter int RCD = 2,
   parameter int RAS = 5,
   parameter int RC  = 7,
   parameter int RP  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic act,
   input  logic pre,
   output logic is_open,
   output logic rw_ok,
   output logic pre_ok,
   output logic act_ok,
   output logic rp_ok
);

   logic rc_ok;

   pacer_timer #(.CYC(RCD), .RST_FULL(1'b0)) u_rcd (.clk(clk), .rst(rst), .start(act), .idle(rw_ok));
   pacer_timer #(.CYC(RAS), .RST_FULL(1'b0)) u_ras (.clk(clk), .rst(rst), .start(act), .idle(pre_ok));
   pacer_timer #(.CYC(RC),  .RST_FULL(1'b0)) u_rc  (.clk(clk), .rst(rst), .start(act), .idle(rc_ok));
   pacer_timer #(.CYC(RP),  .RST_FULL(1'b0)) u_rp  (.clk(clk), .rst(rst), .start(pre), .idle(rp_ok));

   assign act_ok = rc_ok & rp_ok;

   always_ff @(posedge clk) begin
      if (rst)      is_open <= 1'b0;
      else if (act) is_open <= 1'b1;
      else if (pre) is_open <= 1'b0;
   end

   // R3
   act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      act |-> (rc_ok && rp_ok));

   // R4
   pre_ras_chk: assert property (@(posedge clk) disable iff (rst)
      (pre && is_open) |-> pre_ok);

endmodule

// File: rtl/pacer_refresh_due.sv
module pacer_refresh_due #(
   parameter int REFI_CYC = 1560,
   parameter int MAX_OWED = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_done,
   output logic owed_nz
);

   localparam int CW = $clog2(REFI_CYC);
   localparam int OW = $clog2(MAX_OWED + 1);
   localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);
   localparam logic [OW-1:0] CAP  = OW'(MAX_OWED);

   logic [CW-1:0] tick_cnt;
   logic [OW-1:0] owed;
   logic          tick;

   assign tick    = (tick_cnt == LAST);
   assign owed_nz = (owed != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_cnt <= '0;
         owed     <= '0;
      end else begin
         tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
         case ({tick, ref_done})
            2'b10:   if (owed != CAP) owed <= owed + 1'b1;
            2'b01:   owed <= owed - 1'b1;
            default: owed <= owed;
         endcase
      end
   end

   // R7
   owed_cap_chk: assert property (@(posedge clk) disable iff (rst)
      owed <= CAP);

   // R8
   ref_only_owed_chk: assert property (@(posedge clk) disable iff (rst)
      ref_done |-> owed_nz);

endmodule

// File: rtl/sdram_cmd_pacer.sv
module sdram_cmd_pacer #(
   parameter int BANK_W    = 2,
   parameter int TCK_PS    = 10000,
   parameter int T_RCD_PS  = 20000,
   parameter int T_RP_PS   = 20000,
   parameter int T_RRD_PS  = 15000,
   parameter int T_RAS_PS  = 45000,
   parameter int T_RC_PS   = 65000,
   parameter int T_RFC_PS  = 75000,
   parameter int T_REFI_PS = 15600000,
   parameter int MRD_CYC   = 2,
   parameter int DLL_CYC   = 200,
   parameter int MAX_OWED  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dll_relock,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [BANK_W-1:0] req_bank,
   output logic              req_ready,
   output logic              cmd_valid,
   output logic [2:0]        cmd_code,
   output logic [BANK_W-1:0] cmd_bank
);
   import pacer_pkg::*;

   localparam int BANKS    = 1 << BANK_W;
   localparam int RCD_CYC  = ps_to_cyc(T_RCD_PS, TCK_PS);
   localparam int RP_CYC   = ps_to_cyc(T_RP_PS, TCK_PS);
   localparam int RRD_CYC  = ps_to_cyc(T_RRD_PS, TCK_PS);
   localparam int RAS_CYC  = ps_to_cyc(T_RAS_PS, TCK_PS);
   localparam int RC_CYC   = ps_to_cyc(T_RC_PS, TCK_PS);
   localparam int RFC_CYC  = ps_to_cyc(T_RFC_PS, TCK_PS);
   localparam int REFI_CYC = ps_to_cyc(T_REFI_PS, TCK_PS);

   initial begin
      assert (BANK_W >= 1 && BANK_W <= 3) else $error("BANK_W out of range");
      assert (TCK_PS > 0) else $error("TCK_PS must be positive");
      assert (RFC_CYC >= 2 && MRD_CYC >= 2) else $error("RFC/MRD below two clocks");
      assert (REFI_CYC >= 2 && MAX_OWED >= 1) else $error("refresh settings invalid");
   end

   pacer_cmd_e want;
   logic [BANKS-1:0] b_open, b_rw_ok, b_pre_ok, b_act_ok, b_rp_ok, b_act, b_pre;
   logic rrd_idle, mrd_idle, rfc_idle, dll_idle, owed_nz;
   logic global_ok, any_open, all_rp, open_ras_ok, fe_ok, take_fe, do_pall, do_ref;

   assign want = pacer_cmd_e'(req_cmd);

   generate
      for (genvar i = 0; i < BANKS; i++) begin : g_bank
         assign b_act[i] = take_fe && (want == CMD_ACT) && (req_bank == BANK_W'(i));
         assign b_pre[i] = (take_fe && (want == CMD_PRE) && (req_bank == BANK_W'(i))) || do_pall;
         pacer_bank #(.RCD(RCD_CYC), .RAS(RAS_CYC), .RC(RC_CYC), .RP(RP_CYC)) u_bank (
            .clk(clk), .rst(rst), .act(b_act[i]), .pre(b_pre[i]),
            .is_open(b_open[i]), .rw_ok(b_rw_ok[i]), .pre_ok(b_pre_ok[i]),
            .act_ok(b_act_ok[i]), .rp_ok(b_rp_ok[i]));
      end
   endgenerate

   pacer_timer #(.CYC(RRD_CYC), .RST_FULL(1'b0)) u_rrd (.clk(clk), .rst(rst), .start(|b_act), .idle(rrd_idle));
   pacer_timer #(.CYC(MRD_CYC), .RST_FULL(1'b0)) u_mrd (.clk(clk), .rst(rst),
      .start(take_fe && (want == CMD_MODE)), .idle(mrd_idle));
   pacer_timer #(.CYC(RFC_CYC), .RST_FULL(1'b0)) u_rfc (.clk(clk), .rst(rst), .start(do_ref), .idle(rfc_idle));
   pacer_timer #(.CYC(DLL_CYC), .RST_FULL(1'b1)) u_dll (.clk(clk), .rst(rst), .start(dll_relock), .idle(dll_idle));

   pacer_refresh_due #(.REFI_CYC(REFI_CYC), .MAX_OWED(MAX_OWED)) u_due (
      .clk(clk), .rst(rst), .ref_done(do_ref), .owed_nz(owed_nz));

   assign global_ok   = mrd_idle & rfc_idle;
   assign any_open    = |b_open;
   assign all_rp      = &b_rp_ok;
   assign open_ras_ok = &(b_pre_ok | ~b_open);

   always_comb begin
      unique case (want)
         CMD_ACT:  fe_ok = b_act_ok[req_bank] & rrd_idle;
         CMD_RD:   fe_ok = b_rw_ok[req_bank] & dll_idle;
         CMD_WR:   fe_ok = b_rw_ok[req_bank];
         CMD_PRE:  fe_ok = b_pre_ok[req_bank];
         CMD_MODE: fe_ok = all_rp;
         default:  fe_ok = 1'b0;
      endcase
   end

   assign req_ready = !owed_nz && global_ok && fe_ok;
   assign take_fe   = req_valid && req_ready;
   assign do_pall   = owed_nz && global_ok && any_open && open_ras_ok;
   assign do_ref    = owed_nz && global_ok && !any_open && all_rp;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_valid <= 1'b0;
         cmd_code  <= CMD_NONE;
         cmd_bank  <= '0;
      end else begin
         cmd_valid <= take_fe || do_pall || do_ref;
         cmd_code  <= do_ref ? CMD_REF : do_pall ? CMD_PALL : take_fe ? want : CMD_NONE;
         cmd_bank  <= take_fe ? req_bank : '0;
      end
   end

   // R7
   refresh_prio_chk: assert property (@(posedge clk) disable iff (rst)
      owed_nz |-> !req_ready);

   // R8
   ref_closed_chk: assert property (@(posedge clk) disable iff (rst)
      do_ref |-> (!any_open && !do_pall));

   // R9
   rfc_block_chk: assert property (@(posedge clk) disable iff (rst)
      do_ref |=> (!take_fe && !do_ref && !do_pall));

   // R5
   mrd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (take_fe && want == CMD_MODE) |=> !(take_fe || do_pall || do_ref));

endmodule

// File: tb/tb_sdram_cmd_pacer.sv
module tb_sdram_cmd_pacer;

   // R11: spacings rounded up to whole 10 ns clocks, computed here on their own
   localparam int TCK  = 10000;
   localparam int RCD  = (20000 + TCK - 1) / TCK;
   localparam int RP   = (20000 + TCK - 1) / TCK;
   localparam int RRD  = (15000 + TCK - 1) / TCK;
   localparam int RAS  = (45000 + TCK - 1) / TCK;
   localparam int RC   = (65000 + TCK - 1) / TCK;
   localparam int RFC  = (75000 + TCK - 1) / TCK;
   localparam int REFI = (15600000 + TCK - 1) / TCK;
   localparam int MRD  = 2;
   localparam int DLL  = 200;
   localparam int OWMAX = 8;
   localparam int RUN  = 6000;
   localparam int NEG  = -1000000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dll_relock = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_cmd = 3'd0;
   logic [1:0] req_bank = 2'd0;
   logic       req_ready, cmd_valid;
   logic [2:0] cmd_code;
   logic [1:0] cmd_bank;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sdram_cmd_pacer dut (
      .clk(clk), .rst(rst), .dll_relock(dll_relock),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
      .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank));

   // model state, as edge timestamps
   int last_act[4], last_pre[4];
   bit open_m[4];
   int last_any_act, last_mode, last_ref, dll_edge, owed;
   bit exp_v; int exp_code; int exp_bank;

   task automatic check(input string tag, input int act, input int expv, input string what);
      compared++;
      if (act != expv) begin
         mismatched++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
      end
   endtask

   initial begin
      #(20000 * 10);
      if (!finished) begin
         mismatched++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      bit hold;
      foreach (last_act[b]) begin last_act[b] = NEG; last_pre[b] = NEG; open_m[b] = 0; end
      last_any_act = NEG; last_mode = NEG; last_ref = NEG; dll_edge = -1; owed = 0;
      exp_v = 0; exp_code = 0; exp_bank = 0; hold = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      check("R1", int'(cmd_valid), 0, "cmd_valid in reset");
      check("R1", int'(req_ready && req_cmd != 3'd0), 0, "ready in reset");
      rst = 1'b0;
      for (int e = 0; e < RUN; e++) begin
         bit gok, any_open, ras_ok, all_rp, fe_ok, rdy, take, pall, refr;
         string tag;
         int c, bk;
         if (e != 0) @(negedge clk);
         // drive stimulus
         if (!hold) begin
            int r = $urandom_range(0, 19);
            req_valid = ($urandom_range(0, 9) < 7);
            req_cmd = (r == 0) ? 3'd0 : (r <= 5) ? 3'd1 : (r <= 9) ? 3'd2 : (r <= 13) ? 3'd3 :
                      (r <= 17) ? 3'd4 : (r == 18) ? 3'd5 : 3'(6 + (r & 1));
            req_bank = 2'($urandom_range(0, 3));
         end
         dll_relock = ($urandom_range(0, 499) == 0);
         #1;
         // registered outputs from the previous edge (R10)
         tag = (exp_code == 7) ? "R9" : (exp_code == 6) ? "R8" : "R10";
         check(tag, int'(cmd_valid), int'(exp_v), "cmd_valid");
         if (exp_v) begin
            check(tag, int'(cmd_code), exp_code, "cmd_code");
            check(tag, int'(cmd_bank), exp_bank, "cmd_bank");
         end
         // expected decision at edge e
         c = int'(req_cmd); bk = int'(req_bank);
         gok = (e - last_mode >= MRD) && (e - last_ref >= RFC);
         any_open = 0; ras_ok = 1; all_rp = 1;
         for (int b = 0; b < 4; b++) begin
            if (open_m[b]) begin any_open = 1; if (e - last_act[b] < RAS) ras_ok = 0; end
            if (e - last_pre[b] < RP) all_rp = 0;
         end
         case (c)
            1: fe_ok = (e - last_pre[bk] >= RP) && (e - last_act[bk] >= RC) && (e - last_any_act >= RRD);
            2: fe_ok = (e - last_act[bk] >= RCD) && (e - dll_edge >= DLL);
            3: fe_ok = (e - last_act[bk] >= RCD);
            4: fe_ok = (e - last_act[bk] >= RAS);
            5: fe_ok = all_rp;
            default: fe_ok = 0;
         endcase
         rdy  = (owed == 0) && gok && fe_ok;
         pall = (owed != 0) && gok && any_open && ras_ok;
         refr = (owed != 0) && gok && !any_open && all_rp;
         if (e - last_ref < RFC) tag = "R9";
         else if (e - last_mode < MRD) tag = "R5";
         else if (owed != 0) tag = "R7";
         else case (c)
            1: tag = "R3,R11";
            2: tag = (e - dll_edge < DLL) ? "R6" : "R2,R11";
            3: tag = "R2";
            4: tag = "R4";
            5: tag = "R5";
            default: tag = "R10";
         endcase
         check(tag, int'(req_ready), int'(rdy), "req_ready");
         take = req_valid && rdy;
         // commit model at edge e
         exp_v = take || pall || refr;
         exp_code = refr ? 7 : pall ? 6 : take ? c : 0;
         exp_bank = take ? bk : 0;
         if (take) begin
            case (c)
               1: begin last_act[bk] = e; last_any_act = e; open_m[bk] = 1; end
               4: begin last_pre[bk] = e; open_m[bk] = 0; end
               5: last_mode = e;
               default: ;
            endcase
         end
         if (pall) for (int b = 0; b < 4; b++) begin last_pre[b] = e; open_m[b] = 0; end
         if (refr) last_ref = e;
         if (dll_relock) dll_edge = e;
         if ((e % REFI) == REFI - 1 && !refr) begin if (owed < OWMAX) owed++; end
         else if (refr && (e % REFI) != REFI - 1) owed--;
         // R10: a valid held request stays until taken
         hold = req_valid && !take && (c >= 1 && c <= 5);
      end
      @(negedge clk); #1;
      check("R10", int'(cmd_valid), int'(exp_v), "cmd_valid final");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule